// File: doc/BRIEF.md
# Phase-Aligned Three-Bank Clock Divider with Glitch-Free Gating

This block takes one fast reference clock and produces eight divided clock outputs arranged in three banks: bank A drives four outputs, bank B three and bank C one. Each bank has its own ratio select pin that chooses between two divide ratios. All outputs are registered logic levels clocked by the reference clock. A ratio-N output holds each level for N reference cycles: high for N cycles, then low for N cycles. A single shared 3-bit phase counter defines an 8-cycle frame. Every output starts its high level at frame phase 0, so the banks stay phase-aligned whatever ratios they use.

An active-low master reset clears the outputs asynchronously. An asynchronous output enable passes through a two-stage synchronizer. A started frame always runs to its end. When the synchronized enable is seen low at the last phase of a frame, every output is parked low. Because the last phase is a low phase for every ratio, no high pulse is ever cut short. Within that final frame the ratio-4 outputs make their last fall first, then the ratio-2 outputs, then the ratio-1 outputs. Ratio selects are sampled only at frame boundaries.

The block has no data stream. All pins are plain control or clock-level pins with no handshake.

Top module: `cdiv_fanout`

## Requirements
- R1: While `mrst_n` is low, all eight outputs are 0 at once, without waiting for a clock edge, whatever the enable and select pins are.
- R2: When `mrst_n` is released between clock edges with `out_en` high, all outputs stay 0 after the 1st, 2nd and 3rd rising edges, and are all 1 after the 4th.
- R3: Bank A holds each level for 1 cycle when `div_sel_a` is 0 and for 2 cycles when it is 1. Banks B and C hold each level for 2 cycles when their select is 0 and for 4 cycles when it is 1. Every output begins with its high level.
- R4: All outputs of all banks go high in the same cycle when output starts. Every 8 cycles after that start, all outputs rise together again.
- R5: While the block is stopped (enable held low), all outputs stay 0.
- R6: When `out_en` rises between edges while the block is stopped, all outputs are 0 after the next three rising edges and all 1 after the 4th.
- R7: Let `out_en` fall after the edge of frame cycle d, where cycle index 0 is the first all-high cycle. The outputs follow the R3 pattern up to and including cycle j, the first cycle index ≥ d+3 with j mod 8 = 7. From then on they are 0. As a result, the ratio-4 outputs make their last fall before the ratio-2 outputs, and the ratio-2 outputs before the ratio-1 outputs.
- R8: An `out_en` low pulse whose synchronized value has returned high before the frame's last cycle leaves the output pattern unchanged.
- R9: A select change made mid-frame takes effect at the start of the next frame. The current frame finishes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock; all divided outputs are registered on its rising edge |
| mrst_n | input | 1 | Active-low asynchronous master reset |
| out_en | input | 1 | Asynchronous output enable, 1 = run |
| div_sel_a | input | 1 | Bank A ratio: 0 = 1, 1 = 2 |
| div_sel_b | input | 1 | Bank B ratio: 0 = 2, 1 = 4 |
| div_sel_c | input | 1 | Bank C ratio: 0 = 2, 1 = 4 |
| bank_a_o | output | 4 | Bank A divided outputs |
| bank_b_o | output | 3 | Bank B divided outputs |
| bank_c_o | output | 1 | Bank C divided output |

## Verification
Reset releases are run with four select combinations. Together these cover both ratios of every bank, so a swapped ratio pair in any single bank shows up as a wrong hold length. A mid-frame select change distinguishes frame-boundary sampling from immediate sampling. Disables placed early in a frame and just past the frame's decision point separate a correct drain point from one that is a frame early or late, and check the 4-2-1 order of last falls. A short enable dip tells a frame-end stop decision apart from an immediate stop. A restart from the stopped state checks the enable latency and the realigned phase.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // frame length is 2**PH_BITS cycles; must cover the longest full period
  localparam int unsigned PH_BITS = 3;
  typedef logic [PH_BITS-1:0] phase_t;

  // level hold length selector: 1, 2 or 4 cycles per level
  typedef enum logic [1:0] {
    HOLD_1 = 2'd0,
    HOLD_2 = 2'd1,
    HOLD_4 = 2'd2
  } hold_e;
endpackage

// File: rtl/cdiv_en_sync.sv
module cdiv_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cdiv_phase_seq.sv
module cdiv_phase_seq
  import cdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_s,
  output logic   run,
  output phase_t ph,
  output logic   frame_load
);
  localparam phase_t PH_LAST = '1;

  // idle: phase parked at 0, start on synchronized enable
  // running: count; leave only at the last (all-low) phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      ph  <= '0;
    end else if (!run) begin
      ph  <= '0;
      run <= en_s;
    end else begin
      ph <= ph + 1'b1;
      if (ph == PH_LAST && !en_s) run <= 1'b0;
    end
  end

  // selects may only change when the next phase is 0
  assign frame_load = !run || (ph == PH_LAST);

  // R7: a stop only ever happens at the frame's last phase with enable low
  a_r7_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(ph) == PH_LAST && !$past(en_s)));
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
#(
  parameter int unsigned WIDTH = 1,
  parameter hold_e       LO    = HOLD_1,
  parameter hold_e       HI    = HOLD_2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             frame_load,
  input  phase_t           ph,
  input  logic             sel,
  output logic [WIDTH-1:0] q
);
  logic  sel_q;
  hold_e hold;
  logic  lvl;

  // ratio select held for a whole frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= 1'b1;
    else if (frame_load) sel_q <= sel;
  end

  assign hold = sel_q ? HI : LO;

  // high in the first half of each period, so every ratio is high at phase 0
  always_comb begin
    unique case (hold)
      HOLD_1:  lvl = ~ph[0];
      HOLD_2:  lvl = ~ph[1];
      default: lvl = ~ph[2];
    endcase
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_out
    logic q_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= run & lvl;
    end
    assign q[g] = q_r;
  end

  // checker: every high level lasts its full hold length
  logic [PH_BITS:0] hi_len;
  logic [PH_BITS:0] hold_len;

  always_comb begin
    unique case (hold)
      HOLD_1:  hold_len = (PH_BITS+1)'(1);
      HOLD_2:  hold_len = (PH_BITS+1)'(2);
      default: hold_len = (PH_BITS+1)'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_len <= '0;
    else if (q[0]) hi_len <= hi_len + 1'b1;
    else           hi_len <= '0;
  end

  // R3 / R7: no shortened high pulse, also across a stop
  a_r3_full_high_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q[0]) |-> (hi_len == $past(hold_len)));
endmodule

// File: rtl/cdiv_fanout.sv
module cdiv_fanout
  import cdiv_pkg::*;
#(
  parameter int unsigned A_OUTS      = 4,
  parameter int unsigned B_OUTS      = 3,
  parameter int unsigned C_OUTS      = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_in,
  input  logic              mrst_n,
  input  logic              out_en,
  input  logic              div_sel_a,
  input  logic              div_sel_b,
  input  logic              div_sel_c,
  output logic [A_OUTS-1:0] bank_a_o,
  output logic [B_OUTS-1:0] bank_b_o,
  output logic [C_OUTS-1:0] bank_c_o
);
  logic   en_s;
  logic   run;
  phase_t ph;
  logic   frame_load;

  cdiv_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_in), .rst_n(mrst_n), .d_async(out_en), .q_sync(en_s)
  );

  cdiv_phase_seq u_seq (
    .clk(clk_in), .rst_n(mrst_n), .en_s(en_s),
    .run(run), .ph(ph), .frame_load(frame_load)
  );

  cdiv_bank #(.WIDTH(A_OUTS), .LO(HOLD_1), .HI(HOLD_2)) u_bank_a (
    .clk(clk_in), .rst_n(mrst_n), .run(run), .frame_load(frame_load),
    .ph(ph), .sel(div_sel_a), .q(bank_a_o)
  );

  cdiv_bank #(.WIDTH(B_OUTS), .LO(HOLD_2), .HI(HOLD_4)) u_bank_b (
    .clk(clk_in), .rst_n(mrst_n), .run(run), .frame_load(frame_load),
    .ph(ph), .sel(div_sel_b), .q(bank_b_o)
  );

  cdiv_bank #(.WIDTH(C_OUTS), .LO(HOLD_2), .HI(HOLD_4)) u_bank_c (
    .clk(clk_in), .rst_n(mrst_n), .run(run), .frame_load(frame_load),
    .ph(ph), .sel(div_sel_c), .q(bank_c_o)
  );

  // R4: one cycle after the sequencer starts, every bank is high together
  a_r4_aligned_start: assert property (@(posedge clk_in) disable iff (!mrst_n)
    $rose(run) |=> (&bank_a_o && &bank_b_o && &bank_c_o));

  // R5: once stopped for a full cycle, no bank drives high
  a_r5_low_when_stopped: assert property (@(posedge clk_in) disable iff (!mrst_n)
    (!run && !$past(run)) |-> (bank_a_o == '0 && bank_b_o == '0 && bank_c_o == '0));
endmodule

// File: tb/test_cdiv_fanout.sv
module test_cdiv_fanout;
  logic       clk = 1'b0;
  logic       mrst_n = 1'b0;
  logic       out_en = 1'b0;
  logic       sa = 1'b1, sb = 1'b1, sc = 1'b1;
  logic [3:0] qa;
  logic [2:0] qb;
  logic [0:0] qc;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cdiv_fanout i_cdiv_fanout (
    .clk_in(clk), .mrst_n(mrst_n), .out_en(out_en),
    .div_sel_a(sa), .div_sel_b(sb), .div_sel_c(sc),
    .bank_a_o(qa), .bank_b_o(qb), .bank_c_o(qc)
  );

  function automatic logic [7:0] pack();
    return {qc, qb, qa};
  endfunction

  // expected levels at frame cycle i for the given selects (R3 mapping)
  function automatic logic [7:0] exp_at(int i, logic a, logic b, logic c);
    logic la, lb, lc;
    la = ((i >> (a ? 1 : 0)) & 1) == 0;
    lb = ((i >> (b ? 2 : 1)) & 1) == 0;
    lc = ((i >> (c ? 2 : 1)) & 1) == 0;
    return {lc, {3{lb}}, {4{la}}};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // reset with given selects, release, check R1/R2; leaves at frame cycle 0
  task automatic start_run(logic a, logic b, logic c);
    @(negedge clk);
    mrst_n = 1'b0; out_en = 1'b1; sa = a; sb = b; sc = c;
    #1 chk("R1 held reset", pack(), 8'h00);
    step();
    mrst_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step();
      chk("R2 before 4th edge", pack(), 8'h00);
    end
    step();
    chk("R2/R4 all high at 4th edge", pack(), 8'hFF);
  endtask

  task automatic t_ratios(logic a, logic b, logic c);
    start_run(a, b, c);
    for (int i = 1; i < 24; i++) begin
      step();
      chk("R3/R4 ratio pattern", pack(), exp_at(i, a, b, c));
    end
  endtask

  task automatic t_async_reset();
    start_run(1'b0, 1'b0, 1'b0);
    #2 mrst_n = 1'b0;
    #1 chk("R1 async clear mid-cycle", pack(), 8'h00);
  endtask

  task automatic t_sel_change();
    start_run(1'b1, 1'b1, 1'b1);
    for (int i = 1; i < 32; i++) begin
      step();
      if (i < 16) chk("R9 old ratio to frame end", pack(), exp_at(i, 1'b1, 1'b1, 1'b1));
      else        chk("R9 new ratio from frame start", pack(), exp_at(i, 1'b0, 1'b0, 1'b0));
      if (i == 10) begin sa = 1'b0; sb = 1'b0; sc = 1'b0; end
    end
  endtask

  // disable after frame cycle d; then R6 restart
  task automatic t_disable(int d);
    int j, la, lb, lc;
    start_run(1'b0, 1'b0, 1'b1);
    j = d + 3;
    while ((j % 8) != 7) j++;
    la = -1; lb = -1; lc = -1;
    if (d == 0) out_en = 1'b0;
    for (int i = 1; i <= j + 16; i++) begin
      step();
      if (i <= j) chk("R7 pattern until drain", pack(), exp_at(i, 1'b0, 1'b0, 1'b1));
      else        chk("R5/R7 parked low", pack(), 8'h00);
      if (qa[0]) la = i;
      if (qb[0]) lb = i;
      if (qc[0]) lc = i;
      if (i == d) out_en = 1'b0;
    end
    checks++;
    if (!(lc < lb && lb < la)) begin
      errors++;
      $display("FAIL R7 fall order: last high c=%0d b=%0d a=%0d expected c<b<a", lc, lb, la);
    end
    out_en = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step();
      chk("R6 restart latency low", pack(), 8'h00);
    end
    step();
    chk("R6 restart high at 4th edge", pack(), 8'hFF);
    for (int i = 1; i < 16; i++) begin
      step();
      chk("R6/R4 realigned pattern", pack(), exp_at(i, 1'b0, 1'b0, 1'b1));
    end
  endtask

  task automatic t_dip();
    start_run(1'b0, 1'b1, 1'b0);
    for (int i = 1; i < 32; i++) begin
      step();
      chk("R8 short dip ignored", pack(), exp_at(i, 1'b0, 1'b1, 1'b0));
      if (i == 8)  out_en = 1'b0;
      if (i == 10) out_en = 1'b1;
    end
  endtask

  task automatic t_held_off();
    @(negedge clk);
    mrst_n = 1'b0; out_en = 1'b0;
    step();
    mrst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step();
      chk("R5 enable low keeps outputs low", pack(), 8'h00);
    end
  endtask

  initial begin
    t_held_off();
    t_ratios(1'b1, 1'b1, 1'b1);
    t_ratios(1'b0, 1'b0, 1'b0);
    t_ratios(1'b0, 1'b1, 1'b0);
    t_ratios(1'b1, 1'b0, 1'b1);
    t_async_reset();
    t_sel_change();
    t_disable(9);
    t_disable(13);
    t_dip();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule